// File: doc/BRIEF.md
# Flash toggle-bit status poller

This block runs on the host side of a parallel NOR flash. It watches an embedded program or erase operation until the operation ends. After a start request it reads the 8-bit status byte in pairs through a simple request/valid read port. For each pair it compares the toggle flag (bit 6) of the first read with that of the second read. While the flash is busy the toggle flag flips on every read. When the flag holds steady, the operation has ended.

When the flag is still flipping, the block looks at the timing-limit flag (bit 5) in the second read of the pair. A set limit flag can mean the internal pulse budget ran out, for example after an attempt to program a 0 bit back to 1. The toggle flag can stop flipping at the same moment the limit flag rises, so the block reads one more pair to confirm before it declares a failure. On failure it pulses a request for the host to issue the flash reset command.

An abort input drops an operation at any point. A later start always begins with a fresh pair of reads and reuses no earlier sample. A pair-count limit ends an operation whose toggle flag never settles, so the block cannot hang.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `rd_req_o`, `done_o`, `fail_o` and `reset_cmd_o` are all 0.
- R2: A start in idle raises `rd_req_o` in the next cycle. A read completes in a cycle where `rd_req_o` and `rd_valid_i` are both 1. `rd_req_o` stays high while a read waits for `rd_valid_i`.
- R3: If bit 6 is equal in both reads of a pair, `done_o` pulses in the cycle after the second read completes, and no further read is issued.
- R4: If bit 6 differs within a pair and bit 5 of the pair's second read is 0, the block starts another pair of reads.
- R5: If bit 6 differs and bit 5 of the second read is 1, the block reads one confirming pair. If bit 6 also differs in that pair, `fail_o` and `reset_cmd_o` pulse together.
- R6: If the confirming pair shows equal bit 6 values, `done_o` pulses and `fail_o` stays 0, even though bit 5 was read as 1.
- R7: While `abort_i` is 1 the block returns to idle. In the following cycle `rd_req_o`, `done_o` and `fail_o` are 0. The next start begins with a new first read, and no sample taken before the abort is used.
- R8: After MAX_PAIRS consecutive toggling pairs with bit 5 at 0, `fail_o` and `reset_cmd_o` pulse (timeout).
- R9: `done_o` and `fail_o` are one-cycle pulses, never high together, and at most one of them is raised per operation.
- R10: A start while an operation is in progress is ignored, and it changes neither the read count nor the result.
- R11: Status bits other than 6 and 5 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (accepted only in idle) |
| abort_i | input | 1 | Abandon polling and return to idle |
| rd_req_o | output | 1 | Status read request toward the flash bus |
| rd_valid_i | input | 1 | Read data valid, completes the pending read |
| rd_data_i | input | 8 | Status byte returned by the read |
| done_o | output | 1 | One-cycle pulse: operation complete |
| fail_o | output | 1 | One-cycle pulse: operation failed or timed out |
| reset_cmd_o | output | 1 | One-cycle pulse: host should issue the flash reset command |

## Verification
A wrong stored first sample or a skipped read shows at the ports as a wrong number of reads before the result pulse. For example, a resumed poll that reuses a stale sample finishes one read early. A misrouted decision shows in the cycle after the second read of the deciding pair. Examples are a fail where a confirming pair should follow, or a done for a pair that still toggles. The pair counter is observed only through the timeout fail pulse, which must arrive exactly after 2×MAX_PAIRS reads.

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller #(
  parameter int DATA_W    = 8,
  parameter int TOG_BIT   = 6,
  parameter int LIM_BIT   = 5,
  parameter int MAX_PAIRS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  output logic              rd_req_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic              fail_o,
  output logic              reset_cmd_o
);

  localparam int CW = $clog2(MAX_PAIRS + 1);

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} state_t;

  state_t        state;
  logic          confirm;
  logic          first_tog;
  logic [CW-1:0] pairs;
  logic          done_q, fail_q, rcmd_q;

  wire rd_fire = rd_req_o && rd_valid_i;
  wire toggled = first_tog != rd_data_i[TOG_BIT];
  wire limit   = rd_data_i[LIM_BIT];
  wire last    = pairs == CW'(MAX_PAIRS - 1);

  logic unused_bits;
  assign unused_bits = ^rd_data_i;

  assign rd_req_o    = (state == S_FIRST) || (state == S_SECOND);
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign reset_cmd_o = rcmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      confirm   <= 1'b0;
      first_tog <= 1'b0;
      pairs     <= '0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      rcmd_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      rcmd_q <= 1'b0;
      if (abort_i) begin
        state   <= S_IDLE;
        confirm <= 1'b0;
        pairs   <= '0;
      end else begin
        case (state)
          S_IDLE: if (start_i) begin
            state   <= S_FIRST;
            confirm <= 1'b0;
            pairs   <= '0;
          end
          S_FIRST: if (rd_fire) begin
            first_tog <= rd_data_i[TOG_BIT];
            state     <= S_SECOND;
          end
          S_SECOND: if (rd_fire) begin
            if (!toggled) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else if (confirm) begin
              fail_q <= 1'b1;
              rcmd_q <= 1'b1;
              state  <= S_IDLE;
            end else if (limit) begin
              confirm <= 1'b1;
              state   <= S_FIRST;
            end else if (last) begin
              fail_q <= 1'b1;
              rcmd_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              pairs <= pairs + 1'b1;
              state <= S_FIRST;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_valid_i && !abort_i) |=> rd_req_o);

  a_r3_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rd_valid_i));

  a_r7_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!rd_req_o && !done_o && !fail_o));

  a_r8_pairs_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pairs < CW'(MAX_PAIRS));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !fail_o);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |=> !(done_o || fail_o));

  a_r9_idle_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |-> !rd_req_o);

endmodule

// File: tb/test_flash_toggle_poller.sv
module test_flash_toggle_poller;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 4;

  logic clk = 0, rst_n = 0, start_i = 0, abort_i = 0, rd_valid_i = 0;
  logic [7:0] rd_data_i = 0;
  logic rd_req_o, done_o, fail_o, reset_cmd_o;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] scr [0:15];
  int idx = 0, lat = 0, w = 0;

  flash_toggle_poller #(.MAX_PAIRS(MAXP)) i_flash_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .fail_o(fail_o), .reset_cmd_o(reset_cmd_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] st(input logic t, input logic l);
    return {1'b0, t, l, 5'b0};
  endfunction

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rd_req_o) begin
        if (w >= lat) begin
          rd_valid_i = 1;
          rd_data_i = scr[idx];
          idx++;
          w = 0;
        end else begin
          rd_valid_i = 0;
          w++;
        end
      end else begin
        rd_valid_i = 0;
        w = 0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic run_op(input string req, input int l, input logic exp_fail,
                        input int exp_reads, input logic poke_start);
    int got_d = 0, got_f = 0, got_r = 0, n = 0;
    lat = l;
    idx = 0;
    @(negedge clk);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk({req, " R2 request raised"}, rd_req_o == 1, rd_req_o, 1);
    if (poke_start) begin
      @(negedge clk);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    while (!(done_o || fail_o) && n < 200) begin
      @(negedge clk);
      n++;
    end
    got_d = done_o; got_f = fail_o; got_r = reset_cmd_o;
    chk({req, " result done"}, got_d == !exp_fail, got_d, !exp_fail);
    chk({req, " result fail"}, got_f == exp_fail, got_f, exp_fail);
    chk({req, " reset cmd"}, got_r == exp_fail, got_r, exp_fail);
    chk({req, " read count"}, idx == exp_reads, idx, exp_reads);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk({req, " R9 single pulse"}, !(done_o || fail_o || rd_req_o), done_o + fail_o, 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 rd_req", rd_req_o == 0, rd_req_o, 0);
    chk("R1 done", done_o == 0, done_o, 0);
    chk("R1 fail", fail_o == 0, fail_o, 0);
    chk("R1 reset_cmd", reset_cmd_o == 0, reset_cmd_o, 0);
  endtask

  task automatic t_steady();
    scr[0] = st(1, 0); scr[1] = st(1, 0);
    run_op("R3 steady", 0, 0, 2, 0);
    scr[0] = 8'hFF; scr[1] = 8'h4A;
    run_op("R11 other bits", 1, 0, 2, 0);
  endtask

  task automatic t_toggle_then_done();
    scr[0] = st(0, 0); scr[1] = st(1, 0); scr[2] = st(0, 0); scr[3] = st(0, 0);
    run_op("R4 repoll", 2, 0, 4, 0);
  endtask

  task automatic t_confirm_fail();
    scr[0] = st(0, 0); scr[1] = st(1, 1); scr[2] = st(0, 1); scr[3] = st(1, 1);
    run_op("R5 confirm fail", 0, 1, 4, 0);
  endtask

  task automatic t_confirm_ok();
    scr[0] = st(0, 0); scr[1] = st(1, 1); scr[2] = st(1, 1); scr[3] = st(1, 1);
    run_op("R6 confirm ok", 1, 0, 4, 0);
  endtask

  task automatic t_timeout();
    for (int k = 0; k < 2*MAXP; k++) scr[k] = st(k[0], 0);
    for (int k = 2*MAXP; k < 16; k++) scr[k] = st(0, 0);
    run_op("R8 timeout", 0, 1, 2*MAXP, 0);
  endtask

  task automatic t_busy_start();
    scr[0] = st(1, 0); scr[1] = st(0, 0); scr[2] = st(1, 0); scr[3] = st(1, 0);
    run_op("R10 busy start", 3, 0, 4, 1);
  endtask

  task automatic t_abort();
    int n = 0;
    lat = 0;
    idx = 0;
    scr[0] = st(0, 0); scr[1] = st(1, 0); scr[2] = st(0, 0); scr[3] = st(1, 0);
    @(negedge clk);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (idx < 1 && n < 20) begin
      @(negedge clk);
      n++;
    end
    abort_i = 1;
    @(negedge clk);
    abort_i = 0;
    for (int k = 0; k < 4; k++) begin
      chk("R7 abort quiet", !(rd_req_o || done_o || fail_o), rd_req_o + done_o + fail_o, 0);
      @(negedge clk);
    end
    scr[0] = st(1, 0); scr[1] = st(1, 0);
    run_op("R7 fresh restart", 0, 0, 2, 0);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) scr[k] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_steady();
    t_toggle_then_done();
    t_confirm_fail();
    t_confirm_ok();
    t_timeout();
    t_busy_start();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule